// File: doc/BRIEF.md
# USB Endpoint Status Command Logic

This block keeps the status flags of every physical endpoint of a USB device controller. It accepts a byte-wide command, a set-status code in the range 0x40 to 0x40 plus the endpoint count minus one, followed by one data byte. The data byte writes the endpoint's stall, disable and rate-feedback flags. For the control OUT endpoint it also writes a conditional-stall flag that can stall both control endpoints at once. SETUP token strobes unstall a stalled control endpoint. Acknowledged data packets advance the per-endpoint data toggle.

Any write to an endpoint's stall flag, and any automatic unstall, reinitializes that endpoint. The block raises a one-cycle reinitialize pulse on that endpoint's line so the buffer logic flushes it, and it returns the endpoint's toggle to DATA0 (toggle output 0). Endpoints 0 and 1 are the control OUT and control IN pair. Interrupt status is not part of this block, so a reinitialization has no effect on it.

A two-state command machine does the decoding. In `ST_IDLE` a valid set-status code takes the transition *arm* into `ST_WAIT_DATA` and latches the target endpoint. In `ST_WAIT_DATA` a data byte takes *apply* back to `ST_IDLE` and writes the endpoint. A further valid code takes *rearm*: it stays in `ST_WAIT_DATA` and retargets. An invalid code takes *abandon* back to `ST_IDLE`.

Top module: `usb_ep_status`

## Requirements
- R1: After reset every stall, disable, rate-feedback, toggle and reinitialize output is 0, `cond_stall` is 0 and `cmd_pending` is 0.
- R2: A `cmd_valid` with code 0x40+n, n below the endpoint count (22 by default), sets `cmd_pending` at the next edge. The next `dat_valid` byte, without a simultaneous `cmd_valid`, is applied to endpoint n at its edge and clears `cmd_pending`. The updated outputs are visible in the following cycle.
- R3: Codes outside the valid range leave every output unchanged. If a command is pending, such a code abandons it (`cmd_pending` returns to 0). A `dat_valid` while no command is pending changes nothing.
- R4: In the data byte, bit 0 writes stall, bit 5 writes disable and bit 6 writes rate-feedback. Bits 4:1 are discarded. Bit 7 is stored into `cond_stall` only when the target is endpoint 0; for other endpoints it is discarded.
- R5: Every applied write pulses `ep_reinit[n]` high for exactly one cycle and clears `ep_toggle[n]` to DATA0. This holds also when the written stall value equals the current one, including writing 0 to an unstalled endpoint.
- R6: A `setup_stb` for endpoint 0 or 1 while that endpoint is stalled unstalls it, pulses its reinitialize line and clears its toggle. A SETUP for an unstalled endpoint, or for an endpoint index above 1, changes nothing.
- R7: An `ack_stb` flips the toggle of its endpoint unless that endpoint is isochronous or its rate-feedback flag is 1. The isochronous endpoints are set by the parameter `ISO_MASK`, endpoints 4 and 5 by default.
- R8: Writing endpoint 0 with bit 7 set while `setup_pend` is 0 stalls both endpoints 0 and 1, whatever bit 0 is, and reinitializes both.
- R9: Writing endpoint 0 with bit 7 set while `setup_pend` is 1 records `cond_stall` = 1. Endpoint 0 then takes its stall from bit 0, and endpoint 1 is neither changed nor reinitialized.
- R10: Writing endpoint 0 with bit 7 clear while `cond_stall` is 1 unstalls and reinitializes endpoint 1. Endpoint 0 takes its stall from bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command byte strobe |
| cmd_code | input | 8 | Command byte |
| dat_valid | input | 1 | Data byte strobe |
| dat_byte | input | 8 | Data byte for the pending command |
| setup_stb | input | 1 | SETUP token received |
| setup_ep | input | 5 | Endpoint index of the SETUP token |
| setup_pend | input | 1 | Setup-pending flag of the control OUT endpoint |
| ack_stb | input | 1 | Data packet acknowledged |
| ack_ep | input | 5 | Endpoint index of the acknowledged packet |
| cmd_pending | output | 1 | Command machine is in `ST_WAIT_DATA` |
| cond_stall | output | 1 | Stored conditional-stall flag |
| ep_stall | output | 22 | Stall flag per endpoint |
| ep_disable | output | 22 | Disable flag per endpoint |
| ep_rate_fb | output | 22 | Rate-feedback flag per endpoint |
| ep_toggle | output | 22 | Current data toggle per endpoint (0 = DATA0) |
| ep_reinit | output | 22 | One-cycle reinitialize pulse per endpoint |

## Verification
The assertions assume that `cmd_valid` and `dat_valid` are single-cycle strobes taken from one byte source. They also assume that a SETUP strobe does not land in the same cycle as a data byte being applied, since the SETUP checks exclude that cycle. The stimulus drives each strobe for one cycle, between falling edges, and keeps SETUP and acknowledge pulses in cycles of their own. It also holds `setup_pend` steady across each command-and-data pair, so the conditional-stall checks see the level the write actually used.

// File: rtl/usb_eps_pkg.sv
package usb_eps_pkg;

    typedef enum logic [0:0] {
        ST_IDLE      = 1'b0,
        ST_WAIT_DATA = 1'b1
    } cmd_state_e;

    // Field positions inside the set-status data byte
    localparam int FLD_STALL = 0;
    localparam int FLD_DIS   = 5;
    localparam int FLD_RFB   = 6;
    localparam int FLD_CND   = 7;

    typedef struct packed {
        logic stall;
        logic dis;
        logic rfb;
        logic cnd;
    } stat_wr_t;

endpackage

// File: rtl/usb_eps_cmd_fsm.sv
module usb_eps_cmd_fsm
    import usb_eps_pkg::*;
#(
    parameter int         NUM_EP   = 22,
    parameter logic [7:0] CMD_BASE = 8'h40,
    localparam int        EPW      = $clog2(NUM_EP)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cmd_valid,
    input  logic [7:0]     cmd_code,
    input  logic           dat_valid,
    input  logic [7:0]     dat_byte,
    output logic           wr_en,
    output logic [EPW-1:0] wr_ep,
    output stat_wr_t       wr_fld,
    output logic           pending
);

    cmd_state_e     state_q, state_d;
    logic [EPW-1:0] tgt_q, tgt_d;
    logic           code_hit;
    logic [7:0]     code_off;

    always_comb begin
        code_hit = ({1'b0, cmd_code} >= {1'b0, CMD_BASE}) &&
                   ({1'b0, cmd_code} <  ({1'b0, CMD_BASE} + 9'(NUM_EP)));
        code_off = cmd_code - CMD_BASE;
    end

    // next-state and target selection
    always_comb begin
        state_d = state_q;
        tgt_d   = tgt_q;
        unique case (state_q)
            ST_IDLE: begin
                if (cmd_valid && code_hit) begin
                    state_d = ST_WAIT_DATA;              // arm
                    tgt_d   = code_off[EPW-1:0];
                end
            end
            ST_WAIT_DATA: begin
                if (cmd_valid) begin
                    if (code_hit) begin
                        tgt_d = code_off[EPW-1:0];       // rearm
                    end else begin
                        state_d = ST_IDLE;               // abandon
                    end
                end else if (dat_valid) begin
                    state_d = ST_IDLE;                   // apply
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            tgt_q   <= '0;
        end else begin
            state_q <= state_d;
            tgt_q   <= tgt_d;
        end
    end

    // outputs
    always_comb begin
        wr_en        = (state_q == ST_WAIT_DATA) && dat_valid && !cmd_valid;
        wr_ep        = tgt_q;
        wr_fld.stall = dat_byte[FLD_STALL];
        wr_fld.dis   = dat_byte[FLD_DIS];
        wr_fld.rfb   = dat_byte[FLD_RFB];
        wr_fld.cnd   = dat_byte[FLD_CND];
        pending      = (state_q == ST_WAIT_DATA);
    end

endmodule

// File: rtl/usb_eps_ctrl_pair.sv
module usb_eps_ctrl_pair
    import usb_eps_pkg::*;
#(
    parameter int  NUM_EP = 22,
    localparam int EPW    = $clog2(NUM_EP)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic [EPW-1:0] wr_ep,
    input  stat_wr_t       wr_fld,
    input  logic           setup_pend,
    output logic           force_ep0,
    output logic           ld_ep1,
    output logic           val_ep1,
    output logic           cond_q
);

    logic w0, cset, cclr;

    always_comb begin
        w0        = wr_en && (wr_ep == '0);
        cset      = w0 && wr_fld.cnd && !setup_pend;
        cclr      = w0 && !wr_fld.cnd && cond_q;
        force_ep0 = cset;
        ld_ep1    = cset || cclr;
        val_ep1   = cset;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cond_q <= 1'b0;
        end else if (w0) begin
            cond_q <= wr_fld.cnd;
        end
    end

endmodule

// File: rtl/usb_eps_slice.sv
module usb_eps_slice (
    input  logic clk,
    input  logic rst_n,
    input  logic iso,
    input  logic stall_load,
    input  logic stall_val,
    input  logic cfg_load,
    input  logic dis_val,
    input  logic rfb_val,
    input  logic setup_hit,
    input  logic ack_hit,
    output logic stall_q,
    output logic dis_q,
    output logic rfb_q,
    output logic tog_q,
    output logic reinit_q
);

    logic reinit_d, stall_d, tog_d;

    always_comb begin
        reinit_d = stall_load || (setup_hit && stall_q);
        if (stall_load) begin
            stall_d = stall_val;
        end else if (setup_hit) begin
            stall_d = 1'b0;
        end else begin
            stall_d = stall_q;
        end
        if (reinit_d) begin
            tog_d = 1'b0;
        end else if (ack_hit && !iso && !rfb_q) begin
            tog_d = ~tog_q;
        end else begin
            tog_d = tog_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stall_q  <= 1'b0;
            dis_q    <= 1'b0;
            rfb_q    <= 1'b0;
            tog_q    <= 1'b0;
            reinit_q <= 1'b0;
        end else begin
            stall_q  <= stall_d;
            tog_q    <= tog_d;
            reinit_q <= reinit_d;
            if (cfg_load) begin
                dis_q <= dis_val;
                rfb_q <= rfb_val;
            end
        end
    end

endmodule

// File: rtl/usb_ep_status.sv
module usb_ep_status
    import usb_eps_pkg::*;
#(
    parameter int                NUM_EP   = 22,
    parameter logic [7:0]        CMD_BASE = 8'h40,
    parameter logic [NUM_EP-1:0] ISO_MASK = NUM_EP'(32'h30),
    localparam int               EPW      = $clog2(NUM_EP)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [7:0]        cmd_code,
    input  logic              dat_valid,
    input  logic [7:0]        dat_byte,
    input  logic              setup_stb,
    input  logic [EPW-1:0]    setup_ep,
    input  logic              setup_pend,
    input  logic              ack_stb,
    input  logic [EPW-1:0]    ack_ep,
    output logic              cmd_pending,
    output logic              cond_stall,
    output logic [NUM_EP-1:0] ep_stall,
    output logic [NUM_EP-1:0] ep_disable,
    output logic [NUM_EP-1:0] ep_rate_fb,
    output logic [NUM_EP-1:0] ep_toggle,
    output logic [NUM_EP-1:0] ep_reinit
);

    logic           wr_en;
    logic [EPW-1:0] wr_ep;
    stat_wr_t       wr_fld;
    logic           force_ep0, ld_ep1, val_ep1;

    usb_eps_cmd_fsm #(
        .NUM_EP   (NUM_EP),
        .CMD_BASE (CMD_BASE)
    ) fsm_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_code  (cmd_code),
        .dat_valid (dat_valid),
        .dat_byte  (dat_byte),
        .wr_en     (wr_en),
        .wr_ep     (wr_ep),
        .wr_fld    (wr_fld),
        .pending   (cmd_pending)
    );

    usb_eps_ctrl_pair #(
        .NUM_EP (NUM_EP)
    ) pair_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_ep      (wr_ep),
        .wr_fld     (wr_fld),
        .setup_pend (setup_pend),
        .force_ep0  (force_ep0),
        .ld_ep1     (ld_ep1),
        .val_ep1    (val_ep1),
        .cond_q     (cond_stall)
    );

    for (genvar i = 0; i < NUM_EP; i++) begin : g_ep
        localparam logic [EPW-1:0] IDX     = EPW'(i);
        localparam bit             IS_CTL  = (i < 2);
        localparam bit             IS_OUT0 = (i == 0);
        localparam bit             IS_IN1  = (i == 1);

        logic hit, s_load, s_val, su_hit, a_hit;

        always_comb begin
            hit    = wr_en && (wr_ep == IDX);
            s_load = hit || (IS_IN1 && ld_ep1);
            s_val  = hit ? (wr_fld.stall || (IS_OUT0 && force_ep0)) : val_ep1;
            su_hit = IS_CTL && setup_stb && (setup_ep == IDX);
            a_hit  = ack_stb && (ack_ep == IDX);
        end

        usb_eps_slice slice_i (
            .clk        (clk),
            .rst_n      (rst_n),
            .iso        (ISO_MASK[i]),
            .stall_load (s_load),
            .stall_val  (s_val),
            .cfg_load   (hit),
            .dis_val    (wr_fld.dis),
            .rfb_val    (wr_fld.rfb),
            .setup_hit  (su_hit),
            .ack_hit    (a_hit),
            .stall_q    (ep_stall[i]),
            .dis_q      (ep_disable[i]),
            .rfb_q      (ep_rate_fb[i]),
            .tog_q      (ep_toggle[i]),
            .reinit_q   (ep_reinit[i])
        );
    end

endmodule

// File: rtl/usb_eps_checker.sv
module usb_eps_checker #(
    parameter int                NUM_EP   = 22,
    parameter logic [7:0]        CMD_BASE = 8'h40,
    parameter logic [NUM_EP-1:0] ISO_MASK = NUM_EP'(32'h30),
    localparam int               EPW      = $clog2(NUM_EP)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid,
    input logic [7:0]        cmd_code,
    input logic              dat_valid,
    input logic [7:0]        dat_byte,
    input logic              setup_stb,
    input logic [EPW-1:0]    setup_ep,
    input logic              setup_pend,
    input logic              cmd_pending,
    input logic [NUM_EP-1:0] ep_stall,
    input logic [NUM_EP-1:0] ep_toggle,
    input logic [NUM_EP-1:0] ep_reinit
);

    logic       in_range, wr_now, wr0;
    logic [7:0] last_code;

    always_comb begin
        in_range = (cmd_code >= CMD_BASE) && ({1'b0, cmd_code} < ({1'b0, CMD_BASE} + 9'(NUM_EP)));
        wr_now   = cmd_pending && dat_valid && !cmd_valid;
        wr0      = wr_now && (last_code == CMD_BASE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            last_code <= 8'h00;
        end else if (cmd_valid && in_range) begin
            last_code <= cmd_code;
        end
    end

    p_pending_on_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && in_range |=> cmd_pending);

    p_bad_code_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_pending && cmd_valid && !in_range && !setup_stb |=> !cmd_pending && $stable(ep_stall));

    p_stall_change_reinit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((ep_stall ^ $past(ep_stall)) & ~ep_reinit) == '0);

    p_reinit_data0_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ep_reinit & ep_toggle) == '0);

    p_iso_data0_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ep_toggle & ISO_MASK) == '0);

    p_cond_both_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr0 && dat_byte[7] && !setup_pend |=> ep_stall[1:0] == 2'b11 && ep_reinit[1:0] == 2'b11);

    p_setup_unstall0_r6: assert property (@(posedge clk) disable iff (!rst_n)
        setup_stb && setup_ep == '0 && !wr_now |=> !ep_stall[0]);

    p_setup_unstall1_r6: assert property (@(posedge clk) disable iff (!rst_n)
        setup_stb && setup_ep == EPW'(1) && !wr_now |=> !ep_stall[1]);

endmodule

bind usb_ep_status usb_eps_checker #(
    .NUM_EP   (NUM_EP),
    .CMD_BASE (CMD_BASE),
    .ISO_MASK (ISO_MASK)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_valid   (cmd_valid),
    .cmd_code    (cmd_code),
    .dat_valid   (dat_valid),
    .dat_byte    (dat_byte),
    .setup_stb   (setup_stb),
    .setup_ep    (setup_ep),
    .setup_pend  (setup_pend),
    .cmd_pending (cmd_pending),
    .ep_stall    (ep_stall),
    .ep_toggle   (ep_toggle),
    .ep_reinit   (ep_reinit)
);

// File: tb/usb_ep_status_tb_top.sv
module usb_ep_status_tb_top;

    localparam int N = 22;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cmd_valid = 1'b0;
    logic [7:0]   cmd_code = 8'h00;
    logic         dat_valid = 1'b0;
    logic [7:0]   dat_byte = 8'h00;
    logic         setup_stb = 1'b0;
    logic [4:0]   setup_ep = 5'd0;
    logic         setup_pend = 1'b0;
    logic         ack_stb = 1'b0;
    logic [4:0]   ack_ep = 5'd0;
    logic         cmd_pending, cond_stall;
    logic [N-1:0] ep_stall, ep_disable, ep_rate_fb, ep_toggle, ep_reinit;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    usb_ep_status dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_valid   (cmd_valid),
        .cmd_code    (cmd_code),
        .dat_valid   (dat_valid),
        .dat_byte    (dat_byte),
        .setup_stb   (setup_stb),
        .setup_ep    (setup_ep),
        .setup_pend  (setup_pend),
        .ack_stb     (ack_stb),
        .ack_ep      (ack_ep),
        .cmd_pending (cmd_pending),
        .cond_stall  (cond_stall),
        .ep_stall    (ep_stall),
        .ep_disable  (ep_disable),
        .ep_rate_fb  (ep_rate_fb),
        .ep_toggle   (ep_toggle),
        .ep_reinit   (ep_reinit)
    );

    typedef struct packed {
        logic [7:0] code;
        logic [7:0] data;
        logic       ok;
        logic       stall;
        logic       dis;
        logic       rfb;
        logic       cnd;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{8'h45, 8'h01, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
        '{8'h45, 8'h20, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0},
        '{8'h4A, 8'h7F, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0},
        '{8'h55, 8'h40, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0},
        '{8'h56, 8'h21, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
        '{8'h3F, 8'h01, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
        '{8'h4A, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
        '{8'h43, 8'h81, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    endtask

    task automatic send_cmd(input logic [7:0] c);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_code  = c;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic send_dat(input logic [7:0] d);
        @(negedge clk);
        dat_valid = 1'b1;
        dat_byte  = d;
        @(negedge clk);
        dat_valid = 1'b0;
    endtask

    task automatic write_ep(input logic [7:0] c, input logic [7:0] d);
        send_cmd(c);
        send_dat(d);
    endtask

    task automatic pulse_ack(input int ep);
        @(negedge clk);
        ack_stb = 1'b1;
        ack_ep  = 5'(ep);
        @(negedge clk);
        ack_stb = 1'b0;
    endtask

    task automatic pulse_setup(input int ep);
        @(negedge clk);
        setup_stb = 1'b1;
        setup_ep  = 5'(ep);
        @(negedge clk);
        setup_stb = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog actual=hung expected=done");
        summary();
    end

    initial begin
        logic [N-1:0] s_stall, s_dis, s_rfb;
        logic         s_cnd;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 stall", 32'(ep_stall), 0);
        chk("R1 disable", 32'(ep_disable), 0);
        chk("R1 rate_fb", 32'(ep_rate_fb), 0);
        chk("R1 toggle", 32'(ep_toggle), 0);
        chk("R1 reinit", 32'(ep_reinit), 0);
        chk("R1 cond/pending", {30'd0, cond_stall, cmd_pending}, 0);

        // Vector table walk: R2 R3 R4
        for (int v = 0; v < NV; v++) begin
            int ep;
            ep = int'(VECS[v].code) - 8'h40;
            s_stall = ep_stall; s_dis = ep_disable; s_rfb = ep_rate_fb; s_cnd = cond_stall;
            send_cmd(VECS[v].code);
            chk("R2 pending after code", 32'(cmd_pending), 32'(VECS[v].ok));
            send_dat(VECS[v].data);
            if (VECS[v].ok) begin
                chk("R4 stall field", 32'(ep_stall[ep]), 32'(VECS[v].stall));
                chk("R4 disable field", 32'(ep_disable[ep]), 32'(VECS[v].dis));
                chk("R4 rate_fb field", 32'(ep_rate_fb[ep]), 32'(VECS[v].rfb));
                chk("R4 cond_stall", 32'(cond_stall), 32'(VECS[v].cnd));
                chk("R5 reinit pulse", 32'(ep_reinit), 32'(1) << ep);
                chk("R2 pending cleared", 32'(cmd_pending), 0);
            end else begin
                chk("R3 stall unchanged", 32'(ep_stall), 32'(s_stall));
                chk("R3 disable unchanged", 32'(ep_disable), 32'(s_dis));
                chk("R3 rate_fb unchanged", 32'(ep_rate_fb), 32'(s_rfb));
                chk("R3 cond unchanged", 32'(cond_stall), 32'(s_cnd));
                chk("R3 no reinit", 32'(ep_reinit), 0);
            end
        end

        // R3: invalid code abandons a pending command, later data ignored
        s_stall = ep_stall; s_dis = ep_disable;
        send_cmd(8'h48);
        send_cmd(8'h60);
        chk("R3 abandon", 32'(cmd_pending), 0);
        send_dat(8'h21);
        chk("R3 data after abandon stall", 32'(ep_stall), 32'(s_stall));
        chk("R3 data after abandon dis", 32'(ep_disable), 32'(s_dis));
        chk("R3 data after abandon reinit", 32'(ep_reinit), 0);

        // R7: toggle on acknowledge
        pulse_ack(2);
        chk("R7 toggle ep2 first", 32'(ep_toggle[2]), 1);
        pulse_ack(2);
        chk("R7 toggle ep2 second", 32'(ep_toggle[2]), 0);
        pulse_ack(4);
        chk("R7 iso ep4 holds", 32'(ep_toggle[4]), 0);
        write_ep(8'h46, 8'h40);
        pulse_ack(6);
        chk("R7 rate_fb ep6 holds", 32'(ep_toggle[6]), 0);

        // R5: writing 0 to unstalled endpoint still reinitializes
        pulse_ack(2);
        chk("R7 toggle ep2 set", 32'(ep_toggle[2]), 1);
        write_ep(8'h42, 8'h00);
        chk("R5 reinit ep2", 32'(ep_reinit[2]), 1);
        chk("R5 toggle DATA0", 32'(ep_toggle[2]), 0);
        chk("R5 stall stays 0", 32'(ep_stall[2]), 0);
        @(negedge clk);
        chk("R5 pulse one cycle", 32'(ep_reinit[2]), 0);

        // R6: SETUP unstalls control endpoint
        write_ep(8'h40, 8'h01);
        chk("R6 ep0 stalled", 32'(ep_stall[0]), 1);
        pulse_ack(0);
        chk("R6 ep0 toggle 1", 32'(ep_toggle[0]), 1);
        pulse_setup(0);
        chk("R6 setup unstall", 32'(ep_stall[0]), 0);
        chk("R6 setup reinit", 32'(ep_reinit[0]), 1);
        chk("R6 setup toggle", 32'(ep_toggle[0]), 0);
        pulse_setup(0);
        chk("R6 setup unstalled no reinit", 32'(ep_reinit), 0);
        write_ep(8'h47, 8'h01);
        pulse_setup(7);
        chk("R6 setup ep7 ignored stall", 32'(ep_stall[7]), 1);
        chk("R6 setup ep7 no reinit", 32'(ep_reinit), 0);

        // R8: conditional stall without setup pending
        setup_pend = 1'b0;
        write_ep(8'h40, 8'h80);
        chk("R8 both stalled", 32'(ep_stall[1:0]), 3);
        chk("R8 both reinit", 32'(ep_reinit[1:0]), 3);
        chk("R8 cond set", 32'(cond_stall), 1);

        // R10: clearing conditional stall
        write_ep(8'h40, 8'h00);
        chk("R10 both unstalled", 32'(ep_stall[1:0]), 0);
        chk("R10 ep1 reinit", 32'(ep_reinit[1]), 1);
        chk("R10 cond clear", 32'(cond_stall), 0);

        // R9: conditional stall blocked by setup pending
        setup_pend = 1'b1;
        write_ep(8'h40, 8'h80);
        chk("R9 ep0 follows bit0", 32'(ep_stall[0]), 0);
        chk("R9 ep1 unchanged", 32'(ep_stall[1]), 0);
        chk("R9 ep1 no reinit", 32'(ep_reinit[1]), 0);
        chk("R9 cond recorded", 32'(cond_stall), 1);
        setup_pend = 1'b0;

        // R3: data with no pending command
        s_stall = ep_stall;
        send_dat(8'h01);
        chk("R3 idle data ignored", 32'(ep_stall), 32'(s_stall));
        chk("R3 idle data no reinit", 32'(ep_reinit), 0);

        summary();
    end

endmodule